// File: doc/BRIEF.md
# Hold-Flag Instruction Fetch Stage

This block is the fetch and issue stage of a statically scheduled pipeline. It reads one instruction word per cycle from a synchronous instruction cache and hands each word downstream together with its word address. Every 40-bit word carries a hold flag. A word with the flag set is kept in a local holding register and stays there for one extra cycle before it issues. That extra cycle is a dynamic bubble: the cache is not read again, the result-latch clock enable stays low, and the control lines toward the datapath do not move.

The cache port is a plain request/address pair. The word comes back on the data input with a valid strobe in the cycle after the request. A low valid in that cycle is a miss, and the stage repeats the request. A stall input blocks both new reads and issue. A word that returns during a stall is kept, not lost. The issue outputs are registered, so each one shows the decision taken in the cycle before. A read counter lets a test confirm that reads were suppressed.

Top module: `nop_hold_fetch`

## Requirements
- R1: A synchronous active-high reset clears the PC to word address 0, clears the read counter and drives `icReq`, `issueValid` and `dpClkEn` low. In the first cycle after reset is released, a request goes out for address 0.
- R2: When no word carries the hold flag and there are no stalls or misses, words issue in ascending word-address order, one per cycle, back to back. `pcOut` shows the address of the issued word, and `issueWord` is the word returned by the cache.
- R3: The hold flag is bit 39 of the word. A word with the flag set issues exactly one cycle later than it otherwise would, and only once. The next word then follows at the next address with no further delay.
- R4: When a word with the hold flag arrives from the cache and `stallIn` is low, `icReq` is low in that cycle.
- R5: `icReq` is low in every cycle in which `stallIn` is high. `issueValid` is low in the cycle after any stall cycle. A word that returns during a stall is still issued later, in order.
- R6: `dpClkEn` is high exactly when `issueValid` is high and bit 38 (the writes-result flag) of `issueWord` is set.
- R7: In every cycle in which `issueValid` is low, `ctrlOut` (bits 37:30 of the last issued word) and `issueWord` keep their previous values.
- R8: `readCount` increases by exactly one in the cycle after each cycle with `icReq` high, and holds its value otherwise.
- R9: When the response cycle of a request has `icValid` low and `stallIn` is low, the stage requests the same address again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stallIn | input | 1 | Downstream stall; blocks reads and issue |
| icReq | output | 1 | Instruction-cache read request |
| icAddr | output | PC_W | Word address of the request |
| icData | input | WORD_W | Returned instruction word |
| icValid | input | 1 | Returned word valid (cycle after request) |
| pcOut | output | PC_W | Word address of the issued word |
| issueWord | output | WORD_W | Issued instruction word |
| issueValid | output | 1 | Issue slot carries a real instruction |
| ctrlOut | output | CTRL_W | Control field driven to the datapath |
| dpClkEn | output | 1 | Clock enable for datapath result latches |
| readCount | output | CNT_W | Number of cache read requests made |

## Verification
The bound checker watches, on every cycle:
- that no read goes out during a stall or while a freshly arrived held word is waiting;
- that a held arrival or a stall is followed by an empty issue slot;
- that the clock enable matches the issued word's writes-result flag;
- that control and word outputs are frozen in empty slots;
- the read-counter steps and the re-request after a miss.

Some properties only the bench's scenarios can show:
- in-order delivery with no word lost across stalls and misses;
- back-to-back throughput;
- that a held word costs exactly one cycle and is not held a second time.

The bench shows these with a scoreboard of expected addresses and with per-issue gap checks.

// File: rtl/nop_fetch_pkg.sv
package nop_fetch_pkg;
  localparam int DEF_WORD_W = 40;
  localparam int DEF_PC_W   = 16;
  localparam int DEF_CTRL_W = 8;
  localparam int DEF_CNT_W  = 32;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic arrive;    // cache word is present this cycle
    logic holdNow;   // dynamic bubble cycle for a fresh held word
    logic issueNow;  // current word leaves the stage
    logic reqNow;    // cache read request
  } fetchStrobes_t;
endpackage

// File: rtl/nop_fetch_ctrl.sv
module nop_fetch_ctrl
  import nop_fetch_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          stallIn,
  input  logic          icValid,
  input  logic          arrHold,
  output fetchStrobes_t strb
);
  logic pend;     // a request went out last cycle
  logic bufFull;  // holding register has a word
  logic bufHold;  // hold flag of buffered word
  logic bufHeld;  // buffered word already spent its bubble

  logic arrive, curValid, curHold, curHeld, waitHold;
  logic holdNow, issueNow, reqNow;

  always_comb begin
    arrive   = pend & icValid;
    curValid = arrive | bufFull;
    curHold  = arrive ? arrHold : bufHold;
    curHeld  = arrive ? 1'b0 : bufHeld;
    waitHold = curValid & curHold & ~curHeld;
    holdNow  = waitHold & ~stallIn;
    issueNow = curValid & ~stallIn & ~waitHold;
    reqNow   = ~rst & ~stallIn & ~holdNow & (~curValid | issueNow);
  end

  always_comb begin
    strb.arrive   = arrive;
    strb.holdNow  = holdNow;
    strb.issueNow = issueNow;
    strb.reqNow   = reqNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      bufFull <= 1'b0;
      bufHold <= 1'b0;
      bufHeld <= 1'b0;
    end else begin
      pend <= reqNow;
      if (issueNow) begin
        bufFull <= 1'b0;
        bufHeld <= 1'b0;
      end else if (curValid) begin
        bufFull <= 1'b1;
        bufHold <= curHold;
        bufHeld <= curHeld | holdNow;
      end
    end
  end
endmodule

// File: rtl/nop_fetch_dpath.sv
module nop_fetch_dpath
  import nop_fetch_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int PC_W   = DEF_PC_W,
  parameter int CTRL_W = DEF_CTRL_W,
  parameter int CNT_W  = DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  fetchStrobes_t     strb,
  input  logic [WORD_W-1:0] icData,
  output logic [PC_W-1:0]   icAddr,
  output logic [PC_W-1:0]   pcOut,
  output logic [WORD_W-1:0] issueWord,
  output logic              issueValid,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              dpClkEn,
  output logic [CNT_W-1:0]  readCount
);
  localparam int RESW_POS = WORD_W - 2;
  localparam int CTRL_LO  = WORD_W - 2 - CTRL_W;

  logic [PC_W-1:0]   pc, pcNext, bufPc, curPc, pcQ;
  logic [WORD_W-1:0] bufWord, curWord, wordQ;
  logic [CTRL_W-1:0] ctrlQ;
  logic              validQ, clkEnQ;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    curWord = strb.arrive ? icData : bufWord;
    curPc   = strb.arrive ? pc : bufPc;
    pcNext  = pc + {{(PC_W-1){1'b0}}, strb.arrive};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      bufPc   <= '0;
      bufWord <= '0;
      pcQ     <= '0;
      wordQ   <= '0;
      ctrlQ   <= '0;
      validQ  <= 1'b0;
      clkEnQ  <= 1'b0;
      cnt     <= '0;
    end else begin
      pc <= pcNext;
      if (strb.arrive) begin
        bufWord <= icData;
        bufPc   <= pc;
      end
      validQ <= strb.issueNow;
      clkEnQ <= strb.issueNow & curWord[RESW_POS];
      if (strb.issueNow) begin
        wordQ <= curWord;
        pcQ   <= curPc;
        ctrlQ <= curWord[CTRL_LO +: CTRL_W];
      end
      cnt <= cnt + {{(CNT_W-1){1'b0}}, strb.reqNow};
    end
  end

  assign icAddr     = pcNext;
  assign pcOut      = pcQ;
  assign issueWord  = wordQ;
  assign issueValid = validQ;
  assign ctrlOut    = ctrlQ;
  assign dpClkEn    = clkEnQ;
  assign readCount  = cnt;
endmodule

// File: rtl/nop_hold_fetch.sv
module nop_hold_fetch
  import nop_fetch_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int PC_W   = DEF_PC_W,
  parameter int CTRL_W = DEF_CTRL_W,
  parameter int CNT_W  = DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stallIn,
  output logic              icReq,
  output logic [PC_W-1:0]   icAddr,
  input  logic [WORD_W-1:0] icData,
  input  logic              icValid,
  output logic [PC_W-1:0]   pcOut,
  output logic [WORD_W-1:0] issueWord,
  output logic              issueValid,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              dpClkEn,
  output logic [CNT_W-1:0]  readCount
);
  localparam int HOLD_POS = WORD_W - 1;

  fetchStrobes_t strb;

  nop_fetch_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .stallIn (stallIn),
    .icValid (icValid),
    .arrHold (icData[HOLD_POS]),
    .strb    (strb)
  );

  nop_fetch_dpath #(
    .WORD_W(WORD_W), .PC_W(PC_W), .CTRL_W(CTRL_W), .CNT_W(CNT_W)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .icData     (icData),
    .icAddr     (icAddr),
    .pcOut      (pcOut),
    .issueWord  (issueWord),
    .issueValid (issueValid),
    .ctrlOut    (ctrlOut),
    .dpClkEn    (dpClkEn),
    .readCount  (readCount)
  );

  assign icReq = strb.reqNow;
endmodule

// File: rtl/nop_hold_fetch_chk.sv
module nop_hold_fetch_chk #(
  parameter int WORD_W = 40,
  parameter int PC_W   = 16,
  parameter int CTRL_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              stallIn,
  input logic              icReq,
  input logic [PC_W-1:0]   icAddr,
  input logic              icHoldBit,
  input logic              icValid,
  input logic [WORD_W-1:0] issueWord,
  input logic              issueValid,
  input logic [CTRL_W-1:0] ctrlOut,
  input logic              dpClkEn,
  input logic [CNT_W-1:0]  readCount
);
  localparam int RESW_POS = WORD_W - 2;

  AST_STALL_NO_READ: assert property (@(posedge clk) disable iff (rst)
    stallIn |-> !icReq); // R5

  AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    stallIn |=> !issueValid); // R5

  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (icValid && $past(icReq) && icHoldBit && !stallIn) |-> !icReq); // R4

  AST_HOLD_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (icValid && $past(icReq) && icHoldBit && !stallIn) |=> !issueValid); // R3

  AST_CLKEN_QUAL: assert property (@(posedge clk) disable iff (rst)
    dpClkEn |-> (issueValid && issueWord[RESW_POS])); // R6

  AST_CLKEN_ON: assert property (@(posedge clk) disable iff (rst)
    (issueValid && issueWord[RESW_POS]) |-> dpClkEn); // R6

  AST_FREEZE_CTRL: assert property (@(posedge clk) disable iff (rst)
    !issueValid |-> ($stable(ctrlOut) && $stable(issueWord))); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    icReq |=> (readCount == $past(readCount) + 1'b1)); // R8

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !icReq |=> $stable(readCount)); // R8

  AST_MISS_RETRY: assert property (@(posedge clk) disable iff (rst)
    ($past(icReq) && !icValid && !stallIn) |-> (icReq && icAddr == $past(icAddr))); // R9
endmodule

bind nop_hold_fetch nop_hold_fetch_chk #(
  .WORD_W(WORD_W), .PC_W(PC_W), .CTRL_W(CTRL_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stallIn    (stallIn),
  .icReq      (icReq),
  .icAddr     (icAddr),
  .icHoldBit  (icData[WORD_W-1]),
  .icValid    (icValid),
  .issueWord  (issueWord),
  .issueValid (issueValid),
  .ctrlOut    (ctrlOut),
  .dpClkEn    (dpClkEn),
  .readCount  (readCount)
);

// File: tb/nop_hold_fetch_tb.sv
module nop_hold_fetch_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stallIn = 1'b0;
  logic        icReq;
  logic [15:0] icAddr;
  logic [39:0] icData = '0;
  logic        icValid = 1'b0;
  logic [15:0] pcOut;
  logic [39:0] issueWord;
  logic        issueValid;
  logic [7:0]  ctrlOut;
  logic        dpClkEn;
  logic [31:0] readCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  nop_hold_fetch u_dut (
    .clk(clk), .rst(rst), .stallIn(stallIn), .icReq(icReq), .icAddr(icAddr),
    .icData(icData), .icValid(icValid), .pcOut(pcOut), .issueWord(issueWord),
    .issueValid(issueValid), .ctrlOut(ctrlOut), .dpClkEn(dpClkEn),
    .readCount(readCount)
  );

  int total = 0;
  int bad = 0;
  int expQ[$];
  int issuedCnt = 0;
  int holdGapChecks = 0;
  int reqSeen = 0;
  int cyc = 0;
  int lastIssueCyc = -1;
  bit armed = 0;
  bit dirty = 1;
  bit stallPlan = 0;
  bit missPlan = 0;
  bit missNow = 0;
  bit lastReq = 0;
  bit prevStall = 0;
  logic [15:0] lastAddr = '0;
  logic [7:0]  prevCtrl = '0;
  logic [39:0] prevWord = '0;

  // word image: bit39 hold, bit38 writes-result, 37:30 control, 29:0 payload
  function automatic logic [39:0] memWord(input int a);
    logic h;
    h = (a >= 16 && a < 40 && a % 3 == 0) || (a >= 40 && a < 48) || (a >= 48 && a % 4 == 1);
    return {h, 1'((a >> 1) & 1), 8'(a * 37 + 5), 30'(a) ^ 30'h155};
  endfunction

  function automatic bit holdOf(input int a);
    logic [39:0] w;
    w = memWord(a);
    return w[39];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pushExpected(input int n);
    for (int i = 0; i < n; i++) expQ.push_back(i);
  endtask

  // responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (armed) begin
        cyc++;
        chk(readCount == 32'(reqSeen), "R8", "readCount", readCount, reqSeen);
        if (prevStall) chk(!issueValid, "R5", "issue after stall", issueValid, 0);
        chk(dpClkEn == (issueValid & issueWord[38]), "R6", "dpClkEn", dpClkEn,
            issueValid & issueWord[38]);
        if (!issueValid) begin
          chk(ctrlOut == prevCtrl, "R7", "ctrl frozen", ctrlOut, prevCtrl);
          chk(issueWord == prevWord, "R7", "word frozen", issueWord, prevWord);
        end else begin
          if (expQ.size() == 0) begin
            chk(0, "R2", "unexpected issue", pcOut, 0);
          end else begin
            int e;
            e = expQ.pop_front();
            chk(pcOut == 16'(e), "R2", "issue pc order", pcOut, e);
            chk(issueWord == memWord(e), "R2", "issue word", issueWord, memWord(e));
            if (!dirty && lastIssueCyc >= 0) begin
              int g;
              g = 1 + int'(holdOf(e));
              if (holdOf(e)) begin
                holdGapChecks++;
                chk(cyc - lastIssueCyc == g, "R3", "held word gap", cyc - lastIssueCyc, g);
              end else begin
                chk(cyc - lastIssueCyc == g, "R2", "issue gap", cyc - lastIssueCyc, g);
              end
            end
          end
          dirty = 0;
          lastIssueCyc = cyc;
          issuedCnt++;
        end
      end
      prevCtrl = ctrlOut;
      prevWord = issueWord;
      stallIn = stallPlan;
      missNow = 0;
      if (lastReq && missPlan) begin
        icValid = 1'b0;
        missPlan = 0;
        missNow = 1;
      end else begin
        icValid = lastReq;
      end
      icData = lastReq ? memWord(int'(lastAddr)) : 40'h0;
      if (stallIn || missNow) dirty = 1;
      #1;
      if (armed) begin
        if (stallIn) chk(!icReq, "R5", "read during stall", icReq, 0);
        if (icValid && icData[39] && !stallIn)
          chk(!icReq, "R4", "read in hold cycle", icReq, 0);
        if (missNow && !stallIn) begin
          chk(icReq, "R9", "retry request", icReq, 1);
          chk(icAddr == lastAddr, "R9", "retry address", icAddr, lastAddr);
        end
      end
      lastReq = icReq;
      lastAddr = icAddr;
      if (icReq) reqSeen++;
      prevStall = stallIn;
    end
  end

  task automatic waitIssued(input int target, input int budget);
    int n;
    n = 0;
    while (issuedCnt < target && n < budget) begin
      @(negedge clk);
      n++;
    end
    if (issuedCnt < target) chk(0, "WATCHDOG", "issue count", issuedCnt, target);
  endtask

  task automatic stallPulse(input int len);
    @(posedge clk);
    stallPlan = 1;
    repeat (len) @(posedge clk);
    stallPlan = 0;
    repeat (3) @(posedge clk);
  endtask

  task automatic missOnce();
    @(posedge clk);
    missPlan = 1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    pushExpected(200);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!icReq, "R1", "icReq in reset", icReq, 0);
    chk(!issueValid, "R1", "issueValid in reset", issueValid, 0);
    chk(!dpClkEn, "R1", "dpClkEn in reset", dpClkEn, 0);
    chk(pcOut == 0, "R1", "pcOut in reset", pcOut, 0);
    chk(readCount == 0, "R1", "readCount in reset", readCount, 0);
    rst = 1'b0;
    armed = 1;
    #2;
    chk(icReq, "R1", "first request", icReq, 1);
    chk(icAddr == 0, "R1", "first address", icAddr, 0);
    // plain, every-third held, all held regions
    waitIssued(48, 400);
    // stalls of various lengths, including around held words
    stallPulse(1);
    stallPulse(2);
    stallPulse(5);
    stallPulse(1);
    // cache misses, one under a stall
    missOnce();
    missOnce();
    missOnce();
    @(posedge clk);
    missPlan = 1;
    stallPlan = 1;
    repeat (2) @(posedge clk);
    stallPlan = 0;
    repeat (3) @(posedge clk);
    waitIssued(96, 600);
    chk(holdGapChecks > 5, "R3", "held gaps observed", holdGapChecks, 6);
    chk(readCount == 32'(reqSeen), "R8", "final readCount", readCount, reqSeen);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    chk(0, "WATCHDOG", "global timeout", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule